// File: doc/BRIEF.md
# Cell-Framed Transmit Slave with Multi-Port Selection

This block sits on the PHY side of a cell-oriented transmit bus. A master drives 16-bit words together with a start-of-cell flag, an active-low transfer enable, a parity bit and a 5-bit port address. The block registers all of these on the rising clock edge. It frames the accepted words into 27-word cells and stores each cell in a small FIFO that belongs to the addressed port. Each port drives its own cell-space flag back to the master.

On the line side, every port offers a valid/ready word stream. The last word of each cell carries an end-of-cell marker and a parity-error tag. Back-pressure follows the usual rule. A word is consumed on a clock edge where both valid and ready are high. While valid is high and ready is low, the word, its marker and its tag stay unchanged. A cell becomes visible to the reader only once all of its words have been stored. Ready may be held low for as long as needed. When the FIFO is full, a new cell is dropped at its first word and the stored cells are kept.

Configuration pins choose multi-port or single-port operation, cell-level or word-level space signalling, and whether parity is checked and with which sense. These pins are meant to change only while the bus is idle.

Top module: `cell_tx_slave`

## Requirements
- R1: A bus word is taken only on a clock edge where `tx_en_n` is 0. On edges where `tx_en_n` is 1, the data, parity, start and address inputs have no effect.
- R2: A cell is 27 words long. It begins with a word that has `tx_sof`=1, and its 27th word is delivered with `rd_eoc`=1. A word without `tx_sof` that arrives while no cell is open for that port is discarded.
- R3: A word with `tx_sof`=1 that arrives while a cell is partly received discards the partial words. It then opens a new cell.
- R4: With `cfg_par_en`=1, a word has a parity error when the count of ones over `tx_word` and `tx_par` is even (`cfg_par_even`=0) or odd (`cfg_par_even`=1). A cell with any such word is still stored, and its end-of-cell word carries `rd_err`=1. With `cfg_par_en`=0, `tx_par` is ignored and `rd_err` stays 0.
- R5: `par_err_seen[p]` goes to 1 when a word routed to port p has a parity error. It then stays 1 until reset.
- R6: With `cfg_mphy`=1, the address sampled on the first enable-low edge after an enable-high edge selects the port, where address value p selects port p. That port receives every word until enable returns high, even if the address changes. Address 31 and any address of 4 or more select no port, and their words are dropped.
- R7: With `cfg_mphy`=0, the address is ignored and every word goes to port 0.
- R8: With `cfg_cell_level`=1, `tx_space[p]` is 1 exactly when the port's FIFO has at least 27 free word slots. Words of a partly received cell count as used.
- R9: With `cfg_cell_level`=0, `tx_space[p]` is 0 (almost full) exactly when fewer than 4 word slots are free.
- R10: Each port FIFO holds two cells (54 words). A cell whose first word arrives when fewer than 27 slots hold no completed cell is dropped whole.
- R11: The words of a cell appear on `rd_valid` one clock after the edge that samples its 27th word, and not before. Under `rd_valid`=1 and `rd_ready`=0, the word, `rd_eoc` and `rd_err` hold.
- R12: After reset, no port is valid, all space flags are 1 and all error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit byte clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mphy | input | 1 | 1: address selects among ports |
| cfg_cell_level | input | 1 | 1: cell-level space flag, 0: almost-full flag |
| cfg_par_en | input | 1 | Enable parity checking |
| cfg_par_even | input | 1 | 1: even parity, 0: odd parity |
| tx_word | input | 16 | Bus data word |
| tx_par | input | 1 | Parity bit for tx_word |
| tx_sof | input | 1 | First word of a cell |
| tx_en_n | input | 1 | Active-low transfer enable |
| tx_addr | input | 5 | Port address, bit 4 most significant |
| tx_space | output | NPORTS | Per-port cell-space flag |
| rd_ready | input | NPORTS | Line-side ready per port |
| rd_valid | output | NPORTS | Line-side word valid per port |
| rd_data | output | NPORTS*16 | Line-side words, port p at bits p*16 upward |
| rd_eoc | output | NPORTS | End-of-cell marker per port |
| rd_err | output | NPORTS | Parity-error tag on end-of-cell word |
| par_err_seen | output | NPORTS | Sticky parity-error flag per port |

## Verification
The bench goes after these corner cases:
- A start flag in the middle of a cell. A design that fails to roll back would hand out 37 words or a mis-framed cell.
- An address change while enable stays low, and junk data with a start flag during an enable-high gap. Faulty selection or sampling would scatter words to the wrong port or open a false cell.
- A third cell sent into a full FIFO. It must vanish whole without corrupting the two stored cells.
- The space flags, checked at the exact word counts where they must switch in each signalling mode.
- Even, odd and disabled parity. A wrong sense shows up as misplaced `rd_err` tags or error flags.

// File: rtl/cts_pkg.sv
package cts_pkg;
  localparam int WORD_W = 16;

  typedef struct packed {
    logic              eoc;
    logic              err;
    logic [WORD_W-1:0] data;
  } fifo_ent_t;
endpackage

// File: rtl/cts_capture.sv
module cts_capture
  import cts_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_mphy,
  input  logic              cfg_par_en,
  input  logic              cfg_par_even,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              tx_par,
  input  logic              tx_sof,
  input  logic              tx_en_n,
  input  logic [ADDR_W-1:0] tx_addr,
  output logic [NPORTS-1:0] cap_v,
  output logic              cap_sof,
  output logic [WORD_W-1:0] cap_data,
  output logic              cap_perr
);
  localparam logic [ADDR_W-1:0] NULL_ADDR = '1;

  logic              en_n_q;
  logic [NPORTS-1:0] held_sel, sel_now, sel;

  // address decode; the null address and out-of-range values select nothing
  always_comb begin
    sel_now = '0;
    if (!cfg_mphy) begin
      sel_now[0] = 1'b1;
    end else if (tx_addr != NULL_ADDR) begin
      for (int p = 0; p < NPORTS; p++) begin
        if (tx_addr == ADDR_W'(p)) sel_now[p] = 1'b1;
      end
    end
    // selection is taken only on the first enable-low edge
    sel = (!cfg_mphy || en_n_q) ? sel_now : held_sel;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_n_q   <= 1'b1;
      held_sel <= '0;
      cap_v    <= '0;
      cap_sof  <= 1'b0;
      cap_data <= '0;
      cap_perr <= 1'b0;
    end else begin
      en_n_q <= tx_en_n;
      if (!tx_en_n) held_sel <= sel;
      cap_v    <= tx_en_n ? '0 : sel;
      cap_sof  <= tx_sof;
      cap_data <= tx_word;
      cap_perr <= cfg_par_en & ((^{tx_word, tx_par}) == cfg_par_even);
    end
  end
endmodule

// File: rtl/cts_port_fifo.sv
module cts_port_fifo
  import cts_pkg::*;
#(
  parameter int CELL_WORDS = 27,
  parameter int FIFO_CELLS = 2,
  parameter int AF_WORDS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_cell_level,
  input  logic              wr_v,
  input  logic              wr_sof,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              wr_perr,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_eoc,
  output logic              rd_err,
  output logic              clav,
  output logic              perr_seen,
  output logic [$clog2(CELL_WORDS*FIFO_CELLS+1)-1:0] occ
);
  localparam int DEPTH = CELL_WORDS * FIFO_CELLS;
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW    = $clog2(DEPTH + 1);

  fifo_ent_t mem [DEPTH];

  logic [PW-1:0] rd_ptr, wr_ptr, base_ptr;
  logic [CW-1:0] cnt_c, cnt_s, cnt_s_base, wcnt, free_commit, free_all;
  logic          in_cell, cell_err;
  logic          pop, is_sof, admit, store, last, acc_err;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PW-1:0] ptr_back(input logic [PW-1:0] p, input logic [CW-1:0] n);
    int t;
    t = int'(p) - int'(n);
    if (t < 0) t = t + DEPTH;
    return PW'(t);
  endfunction

  always_comb begin
    pop         = rd_valid & rd_ready;
    is_sof      = wr_v & wr_sof;
    free_commit = CW'(DEPTH) - cnt_c;
    admit       = free_commit >= CW'(CELL_WORDS);
    // a start flag rewinds over the partial cell's words
    base_ptr    = is_sof ? ptr_back(wr_ptr, cnt_s) : wr_ptr;
    cnt_s_base  = is_sof ? '0 : cnt_s;
    store       = wr_v & (wr_sof ? admit : in_cell);
    last        = store & (wr_sof ? (CELL_WORDS == 1) : (wcnt == CW'(CELL_WORDS - 1)));
    acc_err     = wr_perr | (~wr_sof & cell_err);
    free_all    = CW'(DEPTH) - cnt_c - cnt_s;
  end

  always_ff @(posedge clk) begin
    if (store) mem[base_ptr] <= '{eoc: last, err: last & acc_err, data: wr_data};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr    <= '0;
      wr_ptr    <= '0;
      cnt_c     <= '0;
      cnt_s     <= '0;
      wcnt      <= '0;
      in_cell   <= 1'b0;
      cell_err  <= 1'b0;
      perr_seen <= 1'b0;
    end else begin
      if (store)       wr_ptr <= ptr_inc(base_ptr);
      else if (is_sof) wr_ptr <= base_ptr;
      cnt_s <= last ? '0 : cnt_s_base + CW'(store);
      cnt_c <= cnt_c - CW'(pop) + (last ? cnt_s_base + 1'b1 : '0);
      if (is_sof)    in_cell <= admit & ~last;
      else if (last) in_cell <= 1'b0;
      if (store) begin
        wcnt     <= wr_sof ? CW'(1) : wcnt + 1'b1;
        cell_err <= acc_err;
      end
      if (pop) rd_ptr <= ptr_inc(rd_ptr);
      perr_seen <= perr_seen | (wr_v & wr_perr);
    end
  end

  assign rd_valid = cnt_c != '0;
  assign rd_data  = mem[rd_ptr].data;
  assign rd_eoc   = mem[rd_ptr].eoc;
  assign rd_err   = mem[rd_ptr].err;
  assign clav     = cfg_cell_level ? (free_all >= CW'(CELL_WORDS)) : (free_all >= CW'(AF_WORDS));
  assign occ      = cnt_c + cnt_s;
endmodule

// File: rtl/cell_tx_slave.sv
module cell_tx_slave
  import cts_pkg::*;
#(
  parameter int NPORTS     = 4,
  parameter int ADDR_W     = 5,
  parameter int CELL_WORDS = 27,
  parameter int FIFO_CELLS = 2,
  parameter int AF_WORDS   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_mphy,
  input  logic                     cfg_cell_level,
  input  logic                     cfg_par_en,
  input  logic                     cfg_par_even,
  input  logic [WORD_W-1:0]        tx_word,
  input  logic                     tx_par,
  input  logic                     tx_sof,
  input  logic                     tx_en_n,
  input  logic [ADDR_W-1:0]        tx_addr,
  output logic [NPORTS-1:0]        tx_space,
  input  logic [NPORTS-1:0]        rd_ready,
  output logic [NPORTS-1:0]        rd_valid,
  output logic [NPORTS*WORD_W-1:0] rd_data,
  output logic [NPORTS-1:0]        rd_eoc,
  output logic [NPORTS-1:0]        rd_err,
  output logic [NPORTS-1:0]        par_err_seen
);
  localparam int OCC_W = $clog2(CELL_WORDS * FIFO_CELLS + 1);

  logic [NPORTS-1:0]       cap_v;
  logic                    cap_sof, cap_perr;
  logic [WORD_W-1:0]       cap_data;
  logic [NPORTS*OCC_W-1:0] occ_all;

  cts_capture #(.NPORTS(NPORTS), .ADDR_W(ADDR_W)) cap_i (
    .clk(clk), .rst_n(rst_n), .cfg_mphy(cfg_mphy), .cfg_par_en(cfg_par_en),
    .cfg_par_even(cfg_par_even), .tx_word(tx_word), .tx_par(tx_par),
    .tx_sof(tx_sof), .tx_en_n(tx_en_n), .tx_addr(tx_addr),
    .cap_v(cap_v), .cap_sof(cap_sof), .cap_data(cap_data), .cap_perr(cap_perr)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    cts_port_fifo #(
      .CELL_WORDS(CELL_WORDS), .FIFO_CELLS(FIFO_CELLS), .AF_WORDS(AF_WORDS)
    ) fifo_i (
      .clk(clk), .rst_n(rst_n), .cfg_cell_level(cfg_cell_level),
      .wr_v(cap_v[p]), .wr_sof(cap_sof), .wr_data(cap_data), .wr_perr(cap_perr),
      .rd_ready(rd_ready[p]), .rd_valid(rd_valid[p]),
      .rd_data(rd_data[p*WORD_W +: WORD_W]), .rd_eoc(rd_eoc[p]), .rd_err(rd_err[p]),
      .clav(tx_space[p]), .perr_seen(par_err_seen[p]),
      .occ(occ_all[p*OCC_W +: OCC_W])
    );
  end
endmodule

// File: rtl/cts_tx_slave_chk.sv
module cts_tx_slave_chk #(
  parameter int NPORTS     = 4,
  parameter int WORD_W     = 16,
  parameter int DEPTH      = 54,
  parameter int OCC_W      = 6
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cfg_mphy,
  input logic                     tx_en_n,
  input logic [NPORTS-1:0]        cap_v,
  input logic [NPORTS-1:0]        rd_ready,
  input logic [NPORTS-1:0]        rd_valid,
  input logic [NPORTS*WORD_W-1:0] rd_data,
  input logic [NPORTS-1:0]        rd_eoc,
  input logic [NPORTS-1:0]        par_err_seen,
  input logic [NPORTS*OCC_W-1:0]  occ_all
);
  // R1: an enable-high edge never produces a captured word
  assert_idle_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en_n |=> cap_v == '0);

  // R6: at most one port receives a given word
  assert_one_port_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cap_v));

  // R7: single-port operation only feeds port 0
  assert_port0_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mphy |=> (cap_v >> 1) == '0);

  for (genvar p = 0; p < NPORTS; p++) begin : g_chk
    // R11: a stalled word holds
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid[p] && !rd_ready[p] |=> rd_valid[p] && $stable(rd_data[p*WORD_W +: WORD_W])
                                     && $stable(rd_eoc[p]));
    // R5: error flag is sticky
    assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      par_err_seen[p] |=> par_err_seen[p]);
    // R10: occupancy never exceeds two cells
    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
      occ_all[p*OCC_W +: OCC_W] <= OCC_W'(DEPTH));
  end
endmodule

bind cell_tx_slave cts_tx_slave_chk #(
  .NPORTS(NPORTS), .WORD_W(16), .DEPTH(CELL_WORDS * FIFO_CELLS),
  .OCC_W($clog2(CELL_WORDS * FIFO_CELLS + 1))
) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_mphy(cfg_mphy), .tx_en_n(tx_en_n), .cap_v(cap_v),
  .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data), .rd_eoc(rd_eoc),
  .par_err_seen(par_err_seen), .occ_all(occ_all)
);

// File: tb/cell_tx_slave_tb_top.sv
`timescale 1ns/1ps
module cell_tx_slave_tb_top;
  localparam int NP   = 4;
  localparam int CELL = 27;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_mphy = 1'b1, cfg_cell_level = 1'b1, cfg_par_en = 1'b1, cfg_par_even = 1'b0;
  logic [15:0]   tx_word = '0;
  logic          tx_par = 1'b0, tx_sof = 1'b0, tx_en_n = 1'b1;
  logic [4:0]    tx_addr = '0;
  logic [NP-1:0] tx_space, rd_ready = '0, rd_valid, rd_eoc, rd_err, par_err_seen;
  logic [NP*16-1:0] rd_data;

  int total = 0, bad = 0;
  logic [17:0]   exp_q[$];
  logic [NP-1:0] exp_flags = '0;

  always #2 clk = ~clk;

  cell_tx_slave dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_mphy(cfg_mphy), .cfg_cell_level(cfg_cell_level),
    .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even), .tx_word(tx_word),
    .tx_par(tx_par), .tx_sof(tx_sof), .tx_en_n(tx_en_n), .tx_addr(tx_addr),
    .tx_space(tx_space), .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_eoc(rd_eoc), .rd_err(rd_err), .par_err_seen(par_err_seen)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic good_par(input logic [15:0] d);
    return cfg_par_even ? ^d : ~^d;
  endfunction

  // enable high with junk on every other input
  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      tx_en_n = 1'b1;
      tx_word = 16'($urandom);
      tx_sof  = 1'b1;
      tx_par  = 1'($urandom);
      tx_addr = 5'($urandom);
    end
  endtask

  task automatic send_cell(input int addr, input int addr_mid, input int first, input int nw,
                           input int bad_idx, input bit keep, input int port);
    bit bad_seen;
    bad_seen = 1'b0;
    for (int i = first; i < first + nw; i++) begin
      logic [15:0] d;
      bit          b;
      d = 16'($urandom);
      b = (i == bad_idx);
      @(negedge clk);
      tx_en_n = 1'b0;
      tx_sof  = (i == 0);
      tx_word = d;
      tx_addr = 5'((i == first) ? addr : addr_mid);
      tx_par  = good_par(d) ^ b;
      if (b && cfg_par_en) begin
        bad_seen = 1'b1;
        if (port >= 0) exp_flags[port] = 1'b1;
      end
      if (keep) exp_q.push_back({(i == CELL - 1), (i == CELL - 1) && bad_seen, d});
    end
    idle(1);
  endtask

  task automatic drain(input int p, input string req);
    int guard;
    logic [17:0] got;
    guard = 0;
    while (exp_q.size() > 0 && guard < 5000) begin
      @(negedge clk);
      guard++;
      rd_ready[p] = ($urandom % 4) != 0;
      if (rd_ready[p] && rd_valid[p]) begin
        got = {rd_eoc[p], rd_err[p], rd_data[p*16 +: 16]};
        chk(got == exp_q[0], req, got, exp_q[0]);
        void'(exp_q.pop_front());
      end
    end
    if (exp_q.size() != 0) begin
      chk(1'b0, req, exp_q.size(), 0);
      exp_q.delete();
    end
    @(negedge clk);
    rd_ready = '0;
    repeat (3) @(negedge clk);
    chk(rd_valid[p] == 1'b0, {req, " no extra words"}, rd_valid[p], 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h1d5e);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(rd_valid == '0, "R12 valid after reset", rd_valid, 0);
    chk(tx_space == '1, "R12 space after reset", tx_space, 4'hf);
    chk(par_err_seen == '0, "R12 flags after reset", par_err_seen, 0);

    // R2 R6 R11: port 2, cell only visible after its last word
    send_cell(2, 2, 0, 26, -1, 1, 2);
    idle(3);
    chk(rd_valid[2] == 1'b0, "R11 partial cell hidden", rd_valid[2], 0);
    send_cell(2, 2, 26, 1, -1, 1, 2);
    chk(rd_valid[2] == 1'b0, "R11 latency early", rd_valid[2], 0);
    @(negedge clk);
    chk(rd_valid[2] == 1'b1, "R11 latency on time", rd_valid[2], 1);
    drain(2, "R2 cell to port 2");

    // R4 R5: bad parity word stored, tagged, flag raised
    send_cell(1, 1, 0, CELL, 5, 1, 1);
    drain(1, "R4 odd parity error tag");
    chk(par_err_seen == exp_flags, "R5 sticky flag port 1", par_err_seen, exp_flags);

    // R3: mid-cell start aborts the partial cell
    send_cell(0, 0, 0, 10, -1, 0, 0);
    send_cell(0, 0, 0, CELL, -1, 1, 0);
    drain(0, "R3 abort partial cell");

    // R1 R6: address change under enable is ignored; junk during enable-high gap
    send_cell(3, 1, 0, 13, -1, 1, 3);
    idle(2);
    send_cell(3, 1, 13, 14, -1, 1, 3);
    chk(rd_valid[1] == 1'b0, "R6 held selection", rd_valid[1], 0);
    drain(3, "R1 gap and held address");

    // R6: null and out-of-range addresses drop words
    send_cell(31, 31, 0, CELL, -1, 0, -1);
    send_cell(7, 7, 0, CELL, -1, 0, -1);
    idle(3);
    chk(rd_valid == '0, "R6 null address dropped", rd_valid, 0);
    chk(tx_space == '1, "R6 null address space", tx_space, 4'hf);

    // R7: single-port mode ignores address
    cfg_mphy = 1'b0;
    send_cell(2, 2, 0, CELL, -1, 1, 0);
    chk(rd_valid[2] == 1'b0, "R7 address ignored", rd_valid[2], 0);
    drain(0, "R7 port 0 only");
    cfg_mphy = 1'b1;

    // R4: even parity, then checking disabled
    cfg_par_even = 1'b1;
    send_cell(2, 2, 0, CELL, -1, 1, 2);
    drain(2, "R4 even parity clean");
    send_cell(2, 2, 0, CELL, 20, 1, 2);
    drain(2, "R4 even parity error");
    cfg_par_en = 1'b0;
    send_cell(0, 0, 0, CELL, 3, 1, 0);
    drain(0, "R4 parity disabled");
    chk(par_err_seen == exp_flags, "R5 flags after parity modes", par_err_seen, exp_flags);
    cfg_par_en = 1'b1;
    cfg_par_even = 1'b0;

    // R8 R10: cell-level space and full FIFO
    send_cell(3, 3, 0, CELL, -1, 1, 3);
    idle(2);
    chk(tx_space[3] == 1'b1, "R8 room for one cell", tx_space[3], 1);
    send_cell(3, 3, 0, 1, -1, 1, 3);
    idle(2);
    chk(tx_space[3] == 1'b0, "R8 no room for a cell", tx_space[3], 0);
    send_cell(3, 3, 1, 26, -1, 1, 3);
    send_cell(3, 3, 0, CELL, -1, 0, 3);
    drain(3, "R10 third cell dropped");
    chk(tx_space[3] == 1'b1, "R8 space back after drain", tx_space[3], 1);

    // R9: word-level almost-full flag
    cfg_cell_level = 1'b0;
    send_cell(1, 1, 0, CELL, -1, 1, 1);
    send_cell(1, 1, 0, 23, -1, 1, 1);
    idle(2);
    chk(tx_space[1] == 1'b1, "R9 four slots free", tx_space[1], 1);
    send_cell(1, 1, 23, 1, -1, 1, 1);
    idle(2);
    chk(tx_space[1] == 1'b0, "R9 three slots free", tx_space[1], 0);
    send_cell(1, 1, 24, 3, -1, 1, 1);
    drain(1, "R9 almost full drain");
    chk(tx_space[1] == 1'b1, "R9 space after drain", tx_space[1], 1);
    cfg_cell_level = 1'b1;

    // R2 R4 R6: random cells
    for (int n = 0; n < 30; n++) begin
      int p, b;
      p = $urandom % NP;
      b = (($urandom % 3) == 0) ? int'($urandom % CELL) : -1;
      cfg_par_even = 1'($urandom);
      send_cell(p, p, 0, CELL, b, 1, p);
      drain(p, "R2 R4 R6 random cell");
    end
    chk(par_err_seen == exp_flags, "R5 final flags", par_err_seen, exp_flags);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule